// File: doc/BRIEF.md
# Programmable Sample-Rate Input Debouncer

This block cleans up a bank of slow digital inputs, such as switch contacts or relay feedback, before logic downstream reads them. Each input first crosses into the clock domain through a two-flop synchronizer. All inputs then share one sampler. A prescaler counts bus clocks and raises a one-clock strobe at a programmable rate. On each strobe, every input bit is sampled and compared with its previous sample. A bit of the filtered data output changes only when two successive samples of that bit agree. Spikes and contact bounce shorter than one sample period therefore never reach the output.

Software controls the block through a 32-bit control register with a plain write strobe and a read-back bus. The register holds an input-enable bit and a 3-bit rate code. It also holds three enable bits for event detection, latch mode and pattern detection. Those three bits are only stored here and drive no logic in this block. While input enable is clear, the filtered output is frozen. After enable is set again, two fresh samples must agree before any bit can change.

Top module: `sample_debouncer`

## Requirements
- R1: The control register resets to 0 and reads back all 32 bits exactly as last written. Bit 7 is input enable and bits 2:0 are the rate code. Bits 6, 5 and 4 (event, latch and pattern enables), bit 3 and bits 31:8 are stored but have no effect on the filtered output.
- R2: The filtered output `data_q` is 0 after reset.
- R3: The rate code sets the number of clocks between sample strobes. Code 0 gives a divider of 1, so a strobe occurs on every clock. Code k from 1 to 7 gives a divider of 2^(6+2k), so code 1 is 256 clocks and code 2 is 1024 clocks.
- R4: Every control write restarts the prescaler from zero. After a write on clock edge W with a nonzero code, the first strobe samples on edge W + divider.
- R5: A filtered bit takes a new value only on a strobe edge where the current sample equals the previous stored sample of that bit. The new sample always replaces the stored sample.
- R6: An input pulse shorter than one sample period never appears on `data_q`. At rate code 0, a one-clock pulse is rejected and a pulse of two or more clocks is passed.
- R7: While input enable is 0, `data_q` holds its value whatever the inputs do.
- R8: When input enable is set by a write on edge W (rate code 0), the first fresh sample is stored on edge W+1 and the output may first change on edge W+2.
- R9: At rate code 0 with input enable set, a steady input change applied before clock edge E1 appears on `data_q` after edge E4. Two of those edges are synchronizer latency.
- R10: A single rate and enable setting applies to every input; the input count is the parameter `NUM_IN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read-back |
| din | input | NUM_IN | Raw asynchronous inputs |
| data_q | output | NUM_IN | Filtered input data |

## Verification
A control write and a sample strobe can land on the same clock edge. At rate code 0 a strobe occurs every clock, so any write collides with one. The bench provokes this by enabling the block and by changing the rate while inputs are steady. It then judges the next output changes against a timeline computed from the requirements. The strobe on the write edge must still act under the old settings, and the restarted prescaler must place the next strobe exactly one divider later. A test at rate codes 1 and 2 checks both the cycle just before and the cycle of the expected update.

// File: rtl/sample_debouncer.sv
module sample_debouncer #(
  parameter int NUM_IN = 8,
  parameter int PRE_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [NUM_IN-1:0] din,
  output logic [NUM_IN-1:0] data_q
);

  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [31:0]       ctrl_q;
  logic              in_en;
  logic [2:0]        rate_sel;
  logic [4:0]        shamt;
  logic [PRE_W-1:0]  lim;
  logic [PRE_W-1:0]  pre_cnt;
  logic              smp_stb;
  logic [NUM_IN-1:0] sync1_q, sync2_q, prev_q, agree;
  logic              vld_q;

  assign cfg_rdata = ctrl_q;
  assign in_en     = ctrl_q[7];
  assign rate_sel  = ctrl_q[2:0];
  assign shamt     = 5'd6 + {1'b0, rate_sel, 1'b0};

  always_comb begin
    if (rate_sel == 3'd0) lim = '0;
    else                  lim = (ONE << shamt) - ONE;
  end

  assign smp_stb = (pre_cnt == lim);
  assign agree   = ~(sync2_q ^ prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (cfg_we) ctrl_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (cfg_we)  pre_cnt <= '0;
    else if (smp_stb) pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= din;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (!in_en) begin
      vld_q <= 1'b0;
    end else if (smp_stb) begin
      prev_q <= sync2_q;
      vld_q  <= 1'b1;
      if (vld_q) data_q <= (data_q & ~agree) | (sync2_q & agree);
    end
  end

endmodule

module sample_debouncer_chk #(
  parameter int NUM_IN = 8,
  parameter int PRE_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              en,
  input logic              strobe,
  input logic [2:0]        rate,
  input logic [PRE_W-1:0]  cnt,
  input logic [NUM_IN-1:0] data
);

  p_cfg_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  p_rate0_every_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 3'd0) |-> strobe);

  p_restart_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cnt == '0);

  p_change_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> $past(en && strobe));

  p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(data));

endmodule

bind sample_debouncer sample_debouncer_chk #(.NUM_IN(NUM_IN), .PRE_W(PRE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .en(in_en), .strobe(smp_stb), .rate(rate_sel),
  .cnt(pre_cnt), .data(data_q)
);

// File: tb/sample_debouncer_tb_top.sv
`timescale 1ns/1ps
module sample_debouncer_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic [N-1:0] din = '0;
  logic [N-1:0] data_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sample_debouncer #(.NUM_IN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .din(din), .data_q(data_q)
  );

  // {pulse[19:12], len[11:8], base[7:0]}
  localparam logic [19:0] VEC [8] = '{
    {8'hFF, 4'd1, 8'h00}, {8'hFF, 4'd2, 8'h00}, {8'hA5, 4'd3, 8'h5A},
    {8'h01, 4'd1, 8'h80}, {8'h3C, 4'd5, 8'hC3}, {8'h0F, 4'd2, 8'hF0},
    {8'h55, 4'd1, 8'hAA}, {8'h12, 4'd4, 8'h34}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset ctrl", cfg_rdata, 32'h0);
    chk("R2 reset data", {24'h0, data_q}, 32'h0);
    rst_n = 1'b1;
    cyc(2);

    // stored-only bits, enable clear: no effect on data (R1, R7)
    wr(32'hA5A5_A570);
    chk("R1 readback", cfg_rdata, 32'hA5A5_A570);
    din = 8'h5A;
    cyc(10);
    chk("R7 disabled hold", {24'h0, data_q}, 32'h0);

    // enable: fresh sample W+1, update W+2 (R8, R5)
    wr(32'h0000_0080);
    cyc(1);
    chk("R8 no update at W+1", {24'h0, data_q}, 32'h0);
    cyc(1);
    chk("R8 update at W+2", {24'h0, data_q}, 32'h5A);

    // latency at code 0 (R9)
    din = 8'hC3;
    cyc(3);
    chk("R9 not yet after E3", {24'h0, data_q}, 32'h5A);
    cyc(1);
    chk("R9 visible after E4", {24'h0, data_q}, 32'hC3);

    // vector table: pulse rejection/pass at code 0 (R6, R5, R10)
    for (int i = 0; i < 8; i++) begin
      logic [7:0] pls, bse;
      int len;
      bit seen;
      pls = VEC[i][19:12];
      len = int'(VEC[i][11:8]);
      bse = VEC[i][7:0];
      din = bse;
      cyc(6);
      seen = 1'b0;
      din = pls;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (data_q == pls) seen = 1'b1;
      end
      din = bse;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (data_q == pls) seen = 1'b1;
      end
      chk("R6 pulse seen", {31'h0, seen}, {31'h0, len >= 2});
      chk("R5 settles to base", {24'h0, data_q}, {24'h0, bse});
    end

    // disable freezes data (R7); re-enable needs two fresh samples (R8)
    din = 8'h0F;
    cyc(6);
    wr(32'h0000_0000);
    din = 8'hF0;
    cyc(10);
    chk("R7 frozen while off", {24'h0, data_q}, 32'h0F);
    wr(32'h0000_0080);
    cyc(1);
    chk("R8 re-enable W+1", {24'h0, data_q}, 32'h0F);
    cyc(1);
    chk("R8 re-enable W+2", {24'h0, data_q}, 32'hF0);

    // code 1: a 200-clock pulse is shorter than 256 (R6)
    din = 8'h0F;
    cyc(6);
    wr(32'h0000_0081);
    cyc(100);
    begin
      bit seen;
      seen = 1'b0;
      din = 8'hF0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (data_q != 8'h0F) seen = 1'b1;
      end
      din = 8'h0F;
      for (int k = 0; k < 600; k++) begin
        @(negedge clk);
        if (data_q != 8'h0F) seen = 1'b1;
      end
      chk("R6 short pulse at code 1", {31'h0, seen}, 32'h0);
    end

    // restart on write; divider 256 (R4, R3)
    @(negedge clk);
    din = 8'h99;
    wr(32'h0000_0081);
    cyc(511);
    chk("R4 before second strobe", {24'h0, data_q}, 32'h0F);
    cyc(1);
    chk("R4 at second strobe", {24'h0, data_q}, 32'h99);

    // code 2: divider 1024 (R3)
    @(negedge clk);
    din = 8'h66;
    wr(32'h0000_0082);
    cyc(2047);
    chk("R3 code 2 before", {24'h0, data_q}, 32'h99);
    cyc(1);
    chk("R3 code 2 update", {24'h0, data_q}, 32'h66);
    chk("R1 final readback", cfg_rdata, 32'h0000_0082);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule